// File: doc/BRIEF.md
# Register-driven JTAG vector shifter

The block drives a four-wire JTAG port from a small window of 32-bit registers. Software sets a bit count and a TMS vector. It then writes a TDI vector, and that write starts the shift. The engine issues the requested number of TCK cycles, least-significant bit first. It captures TDO into a result register, and software reads the result back from the same address it wrote TDI to. Two read-only header words at the bottom of the window let discovery software find the function by walking a capability list.

TCK comes from the system clock through a half-period divider. TCK rests low between transfers. TMS and TDI move only while TCK is low, and TDO is sampled as TCK rises. A plain request/acknowledge strobe interface gives access to the window. The block holds off acknowledging any access to the shift registers until the running transfer ends. A read of the result therefore returns only after every bit has been shifted.

Top module: `jtag_vec_shifter`

## Requirements
- R1: The word at byte offset 0x00 reads 0x0001000B: capability ID 0x000B in bits 15:0, version 1 in bits 19:16, next pointer 0 in bits 31:20. Writes to it are ignored.
- R2: The word at offset 0x04 reads 0x02000008: ID 0x0008 in bits 15:0, revision 0 in bits 19:16, length 0x020 bytes in bits 31:20. Writes to it are ignored.
- R3: The count register at offset 0x0C takes a value from 1 to 32. A write of 0 or of any value above 32 is stored as 32. The register reads back the stored value and resets to 32. Exactly that many TCK rising edges are issued per transfer.
- R4: The TMS vector sits at 0x10. On the k-th TCK rising edge (k from 0), tms_o equals TMS bit k and tdi_o equals bit k of the TDI word. The tdo_i value sampled on that edge is stored in result bit k, which reads at offset 0x14.
- R5: A write to 0x14 starts a transfer, and busy_o is high from the next cycle until the transfer's last TCK falling edge. While busy_o is high, any access to offsets 0x08, 0x0C, 0x10 or 0x14 is not acknowledged; the request is held until the transfer ends.
- R6: TCK is low whenever no transfer runs. tms_o and tdi_o never change while TCK is high.
- R7: The divider at 0x08 sets the length of each TCK phase in system clocks. A write of 0 is stored as 1, the register resets to 1, and it reads back the stored value.
- R8: Result bits at or above the programmed count read as zero. The result is cleared when a new transfer starts, so nothing from an earlier, longer transfer remains.
- R9: A transfer with TMS and TDI both all-zero still issues the full programmed number of TCK cycles.
- R10: Offsets 0x18 and above read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, held until ack_o |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset into the window |
| wdata_i | input | 32 | Write data |
| ack_o | output | 1 | Access accepted this cycle; rdata_o valid for reads |
| rdata_o | output | 32 | Read data |
| busy_o | output | 1 | Transfer in progress |
| tck_o | output | 1 | JTAG clock |
| tms_o | output | 1 | JTAG mode select |
| tdi_o | output | 1 | JTAG data to target |
| tdo_i | input | 1 | JTAG data from target |

## Verification
Two things can meet in one cycle: the end of a transfer, which is the last TCK falling edge and busy_o dropping, and the release of a result read that has been held off. The bench posts the result read right after the TDI write and keeps it pending through the whole shift. It takes the data in the cycle the acknowledge finally appears. It then checks that the returned word holds every sampled TDO bit in place, with the bits above the count at zero. A model of the target drives tdo_i from a pattern, one bit per TCK edge. The bench also records TMS and TDI on every rising edge and measures the phase lengths against the divider.

// File: rtl/jvs_pkg.sv
package jvs_pkg;
  typedef enum logic [5:0] {
    W_EXTHDR = 6'h00,
    W_VSHDR  = 6'h01,
    W_DIV    = 6'h02,
    W_LEN    = 6'h03,
    W_TMS    = 6'h04,
    W_TDX    = 6'h05
  } win_word_e;
endpackage

// File: rtl/jvs_regs.sv
module jvs_regs
  import jvs_pkg::*;
#(
  parameter int unsigned VEC_W   = 32,
  parameter int unsigned LEN_W   = 6,
  parameter int unsigned DIV_W   = 16,
  parameter logic [15:0] CAP_ID  = 16'h000B,
  parameter logic [3:0]  CAP_VER = 4'h1,
  parameter logic [11:0] CAP_NXT = 12'h000,
  parameter logic [15:0] VS_ID   = 16'h0008,
  parameter logic [3:0]  VS_REV  = 4'h0,
  parameter logic [11:0] VS_LEN  = 12'h020
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [7:0]       addr_i,
  input  logic [31:0]      wdata_i,
  input  logic [VEC_W-1:0] res_i,
  output logic [31:0]      rdata_o,
  output logic             shift_hit_o,
  output logic             start_o,
  output logic [LEN_W-1:0] len_o,
  output logic [DIV_W-1:0] div_o,
  output logic [VEC_W-1:0] tms_vec_o,
  output logic [VEC_W-1:0] tdi_vec_o
);
  logic [5:0] word;
  logic [LEN_W-1:0] len_q;
  logic [DIV_W-1:0] div_q;
  logic [VEC_W-1:0] tms_q;
  logic unused_lsb;

  assign word       = addr_i[7:2];
  assign unused_lsb = ^addr_i[1:0];

  assign shift_hit_o = (word == W_DIV) || (word == W_LEN) ||
                       (word == W_TMS) || (word == W_TDX);
  assign start_o   = wr_i && (word == W_TDX);
  assign tdi_vec_o = wdata_i[VEC_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= LEN_W'(VEC_W);
      div_q <= DIV_W'(1);
      tms_q <= '0;
    end else if (wr_i) begin
      unique case (word)
        W_LEN: len_q <= (wdata_i == 32'd0 || wdata_i > 32'(VEC_W))
                        ? LEN_W'(VEC_W) : wdata_i[LEN_W-1:0];
        W_DIV: div_q <= (wdata_i[DIV_W-1:0] == '0) ? DIV_W'(1) : wdata_i[DIV_W-1:0];
        W_TMS: tms_q <= wdata_i[VEC_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (word)
      W_EXTHDR: rdata_o = {CAP_NXT, CAP_VER, CAP_ID};
      W_VSHDR:  rdata_o = {VS_LEN, VS_REV, VS_ID};
      W_DIV:    rdata_o = 32'(div_q);
      W_LEN:    rdata_o = 32'(len_q);
      W_TMS:    rdata_o = 32'(tms_q);
      W_TDX:    rdata_o = 32'(res_i);
      default:  rdata_o = '0;
    endcase
  end

  assign len_o     = len_q;
  assign div_o     = div_q;
  assign tms_vec_o = tms_q;

  AST_LEN_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_q != '0) && (len_q <= LEN_W'(VEC_W))); // R3
  AST_DIV_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_q != '0); // R7
endmodule

// File: rtl/jvs_tck_gen.sv
module jvs_tck_gen #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == half_i - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + DIV_W'(1);
  end

  AST_CNT_BELOW_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < half_i)); // R7
endmodule

// File: rtl/jvs_seq.sv
module jvs_seq #(
  parameter int unsigned VEC_W = 32,
  parameter int unsigned LEN_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [VEC_W-1:0] tms_vec_i,
  input  logic [VEC_W-1:0] tdi_vec_i,
  input  logic             tick_i,
  input  logic             tdo_i,
  output logic             busy_o,
  output logic             tck_o,
  output logic             tms_o,
  output logic             tdi_o,
  output logic [VEC_W-1:0] res_o
);
  localparam int unsigned IDX_W = $clog2(VEC_W);

  logic             busy_q, tck_q;
  logic [LEN_W-1:0] idx_q;
  logic [VEC_W-1:0] tms_sh, tdi_sh, res_q;
  logic             last_bit;

  assign last_bit = (idx_q == len_i - LEN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      tck_q  <= 1'b0;
      idx_q  <= '0;
      tms_sh <= '0;
      tdi_sh <= '0;
      res_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      tck_q  <= 1'b0;
      idx_q  <= '0;
      tms_sh <= tms_vec_i;
      tdi_sh <= tdi_vec_i;
      res_q  <= '0;
    end else if (busy_q && tick_i) begin
      if (!tck_q) begin
        tck_q <= 1'b1;
        res_q[idx_q[IDX_W-1:0]] <= tdo_i;
      end else begin
        tck_q <= 1'b0;
        if (last_bit) begin
          busy_q <= 1'b0;
        end else begin
          idx_q  <= idx_q + LEN_W'(1);
          tms_sh <= tms_sh >> 1;
          tdi_sh <= tdi_sh >> 1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign tck_o  = tck_q;
  assign tms_o  = tms_sh[0];
  assign tdi_o  = tdi_sh[0];
  assign res_o  = res_q;

  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !start_i); // R5
  AST_TCK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !tck_q); // R6
  AST_VEC_HOLD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q) && !$fell(tck_q)) |-> ($stable(tms_sh[0]) && $stable(tdi_sh[0]))); // R6
  AST_IDX_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (idx_q < len_i)); // R3
endmodule

// File: rtl/jtag_vec_shifter.sv
module jtag_vec_shifter #(
  parameter int unsigned VEC_W = 32,
  parameter int unsigned DIV_W = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [7:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic        ack_o,
  output logic [31:0] rdata_o,
  output logic        busy_o,
  output logic        tck_o,
  output logic        tms_o,
  output logic        tdi_o,
  input  logic        tdo_i
);
  localparam int unsigned LEN_W = $clog2(VEC_W + 1);

  logic             shift_hit, start, tick, wr;
  logic [LEN_W-1:0] len;
  logic [DIV_W-1:0] div;
  logic [VEC_W-1:0] tms_vec, tdi_vec, res;

  assign ack_o = req_i && !(busy_o && shift_hit);
  assign wr    = ack_o && we_i;

  jvs_regs #(.VEC_W(VEC_W), .LEN_W(LEN_W), .DIV_W(DIV_W)) u_regs (
    .clk_i, .rst_ni, .wr_i(wr), .addr_i, .wdata_i, .res_i(res),
    .rdata_o, .shift_hit_o(shift_hit), .start_o(start), .len_o(len),
    .div_o(div), .tms_vec_o(tms_vec), .tdi_vec_o(tdi_vec)
  );

  jvs_tck_gen #(.DIV_W(DIV_W)) u_tck (
    .clk_i, .rst_ni, .run_i(busy_o), .half_i(div), .tick_o(tick)
  );

  jvs_seq #(.VEC_W(VEC_W), .LEN_W(LEN_W)) u_seq (
    .clk_i, .rst_ni, .start_i(start), .len_i(len), .tms_vec_i(tms_vec),
    .tdi_vec_i(tdi_vec), .tick_i(tick), .tdo_i, .busy_o, .tck_o, .tms_o,
    .tdi_o, .res_o(res)
  );
endmodule

// File: tb/jtag_vec_shifter_bench.sv
module jtag_vec_shifter_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic ack, busy, tck, tms, tdi;
  logic [31:0] rdata;
  logic tdo = 1'b0;

  always #2 clk = ~clk;

  jtag_vec_shifter u_jtag_vec_shifter (
    .clk_i(clk), .rst_ni, .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .ack_o(ack), .rdata_o(rdata), .busy_o(busy), .tck_o(tck), .tms_o(tms),
    .tdi_o(tdi), .tdo_i(tdo)
  );

  int total = 0, bad = 0;

  task automatic chk(bit ok, string req_tag, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req_tag, what, act, exp);
    end
  endtask

  // target model and TCK monitor, sampled at the falling system clock
  int rc, since_rise, per_min, per_max, hi_cnt, hi_min, hi_max;
  logic [31:0] rec_tms, rec_tdi, pat;
  bit viol, prev_tck;
  logic prev_tms, prev_tdi;

  always @(negedge clk) begin
    if (tck && !prev_tck) begin
      if (rc < 32) begin rec_tms[rc] = tms; rec_tdi[rc] = tdi; end
      if (rc > 0) begin
        if (since_rise < per_min) per_min = since_rise;
        if (since_rise > per_max) per_max = since_rise;
      end
      since_rise = 0;
      hi_cnt = 0;
      rc++;
    end
    if (!tck && prev_tck) begin
      if (hi_cnt < hi_min) hi_min = hi_cnt;
      if (hi_cnt > hi_max) hi_max = hi_cnt;
    end
    if (tck) hi_cnt++;
    since_rise++;
    if (prev_tck && tck && (tms !== prev_tms || tdi !== prev_tdi)) viol = 1;
    prev_tck = tck; prev_tms = tms; prev_tdi = tdi;
    tdo = (rc < 32) ? pat[rc] : 1'b0;
  end

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    #1;
    while (!ack) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req = 0; we = 0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1; we = 0; addr = a;
    #1;
    while (!ack) begin @(negedge clk); #1; end
    d = rdata;
    @(posedge clk); #1;
    req = 0;
  endtask

  task automatic run_shift(int len, logic [31:0] v_tms, logic [31:0] v_tdi,
                           logic [31:0] p, int div);
    int eff, h;
    logic [31:0] mask, rd;
    eff  = (len == 0 || len > 32) ? 32 : len;
    h    = (div == 0) ? 1 : div;
    mask = (eff == 32) ? 32'hFFFF_FFFF : ((32'h1 << eff) - 1);
    bus_write(8'h08, 32'(div));
    bus_write(8'h0C, 32'(len));
    bus_read(8'h0C, rd);
    chk(rd == 32'(eff), "R3", "count readback", rd, eff);
    bus_write(8'h10, v_tms);
    @(negedge clk);
    pat = p; rc = 0; viol = 0;
    per_min = 1 << 20; per_max = 0; hi_min = 1 << 20; hi_max = 0;
    bus_write(8'h14, v_tdi);
    bus_read(8'h14, rd);  // held off until the transfer ends
    chk(!busy && !tck, "R5", "idle after result read", {busy, tck}, 0);
    chk(rc == eff, "R3", "tck rising edges", rc, eff);
    chk((rec_tms & mask) == (v_tms & mask), "R4", "tms order", rec_tms & mask, v_tms & mask);
    chk((rec_tdi & mask) == (v_tdi & mask), "R4", "tdi order", rec_tdi & mask, v_tdi & mask);
    chk(rd == (p & mask), "R8", "result with upper bits clear", rd, p & mask);
    chk(!viol, "R6", "tms/tdi moved while tck high", viol, 0);
    chk(hi_min == h && hi_max == h, "R7", "high phase", hi_max, h);
    if (eff > 1) chk(per_min == 2*h && per_max == 2*h, "R7", "tck period", per_max, 2*h);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'h1D5E_0042));
    repeat (3) @(negedge clk);
    rst_ni = 1;

    // reset state
    chk(!busy && !tck, "R6", "reset idle", {busy, tck}, 0);
    bus_read(8'h08, rd); chk(rd == 1, "R7", "divider reset", rd, 1);
    bus_read(8'h0C, rd); chk(rd == 32, "R3", "count reset", rd, 32);

    // headers, read-only
    bus_write(8'h00, 32'hFFFF_FFFF);
    bus_read(8'h00, rd); chk(rd == 32'h0001_000B, "R1", "ext header", rd, 32'h0001_000B);
    bus_write(8'h04, 32'h1234_5678);
    bus_read(8'h04, rd); chk(rd == 32'h0200_0008, "R2", "vendor header", rd, 32'h0200_0008);
    bus_read(8'h18, rd); chk(rd == 0, "R10", "offset 0x18", rd, 0);
    bus_read(8'h40, rd); chk(rd == 0, "R10", "offset 0x40", rd, 0);

    // divider zero stored as one
    bus_write(8'h08, 0);
    bus_read(8'h08, rd); chk(rd == 1, "R7", "divider zero", rd, 1);

    // directed corners
    run_shift(32, 32'hA5A5_0F0F, 32'h3C3C_F00F, 32'hFFFF_FFFF, 1);
    run_shift(4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 2); // R8 clear on start
    run_shift(1, 32'h1, 32'h0, 32'h1, 3);
    run_shift(0, 32'h8000_0001, 32'h1234_5678, 32'hDEAD_BEEF, 1);  // clamp R3
    run_shift(77, 32'h0, 32'hFFFF_0000, 32'h5555_AAAA, 2);
    run_shift(5, 32'h0, 32'h0, 32'h0, 0);                          // R9 idle clocking

    // stall of shift registers while busy
    bus_write(8'h08, 3);
    bus_write(8'h0C, 32);
    bus_write(8'h14, 32'h0);
    @(negedge clk);
    req = 1; we = 0; addr = 8'h0C;
    for (int i = 0; i < 8; i++) begin
      #1;
      chk(busy && !ack, "R5", "count access held while busy", ack, 0);
      @(negedge clk);
    end
    req = 0;
    bus_read(8'h04, rd); chk(rd == 32'h0200_0008, "R2", "header during shift", rd, 32'h0200_0008);
    bus_read(8'h14, rd);
    chk(!busy, "R5", "busy cleared", busy, 0);

    // random traffic
    for (int n = 0; n < 40; n++) begin
      run_shift($urandom % 40, $urandom, $urandom, $urandom, $urandom % 4);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule